// File: doc/BRIEF.md
# Keyboard and Tape I/O Port Unit

This block is the even-address input/output port of a home-computer video and I/O controller, with a joystick port beside it. A write to any even address latches a byte. Its low three bits drive the border colour, bit 4 drives the speaker (EAR) output and bit 3 drives the MIC output. The whole byte is also kept for a tape loop-back rule.

A read from an even address scans an eight-by-five active-low key matrix. Each of the eight high address bits that is low enables one half-row, and the enabled rows are ANDed together. Bit 6 of the result carries either the live tape input or a loop-back of the stored byte. Which one depends on a load-mode flag and a keyboard-issue select.

A read with address bit 5 low goes to the joystick input, and this path wins over the keyboard path. Read data is registered and updates one clock after the read strobe.

Top module: `kt_port_top`

## Requirements
- R1: A write (`wr_en` high) to an address with bit 0 = 0 sets `border` to data bits 2:0, `ear_out` to data bit 4 and `mic_out` to data bit 3 on the next clock. A write to an odd address changes none of the three.
- R2: A read with address bit 0 = 0 and bit 5 = 1 returns on bits 4:0 the AND of the 5-bit active-low row values of every row r (row r at `key_rows[5r+4:5r]`) whose address bit 8+r is 0. If no such address bit is 0, bits 4:0 read 11111.
- R3: On such a keyboard read, bits 7 and 5 always read 1.
- R4: On a keyboard read with `load_mode` = 1, bit 6 reads 0 when `tape_in` is 1 (active) and reads 1 when it is 0.
- R5: On a keyboard read with `load_mode` = 0 and `old_issue` = 0, bit 6 equals bit 4 of the last byte written to an even address.
- R6: On a keyboard read with `load_mode` = 0 and `old_issue` = 1, bit 6 reads 0 only if bits 4 and 3 of the last written byte were both 0. Otherwise it reads 1.
- R7: A read with address bit 5 = 0 returns `joy_in`, whatever the state of address bit 0.
- R8: A read with address bit 0 = 1 and bit 5 = 1 returns 0xFF.
- R9: Reset sets `border`, `ear_out`, `mic_out` and the stored byte to 0, and sets `rd_data` to 0xFF. `rd_data` changes only on the clock after a cycle with `rd_en` high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | I/O address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| key_rows | input | 40 | Eight 5-bit active-low half-rows, row r at bits 5r+4:5r |
| joy_in | input | 8 | Joystick port value |
| tape_in | input | 1 | Tape input level, 1 = active |
| load_mode | input | 1 | Tape load mode flag |
| old_issue | input | 1 | Older keyboard issue select |
| rd_data | output | 8 | Registered read data |
| border | output | 3 | Border colour |
| ear_out | output | 1 | Speaker (EAR) output |
| mic_out | output | 1 | MIC output |

## Verification
Matrix reads are tried in four patterns:
- a single selected row, which shows that the correct slice is decoded;
- two selected rows with different keys down, which separates an AND from a pick-one implementation;
- no row selected;
- every row selected.

Bit 6 is driven through all four EAR/MIC combinations under both keyboard issues, and these two rules differ only for MIC-only bytes. The tape level is then toggled in load mode. Joystick and odd-address reads are made with keys held down, so that a wrong priority shows up in the returned byte.

// File: rtl/kt_pkg.sv
package kt_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] last_wr;
        logic [DATA_W-1:0] rd;
    } kt_state_t;
endpackage

// File: rtl/kt_row_scan.sv
module kt_row_scan #(
    parameter int NUM_ROWS = 8,
    parameter int ROW_BITS = 5
) (
    input  logic [NUM_ROWS-1:0]          row_sel_n,
    input  logic [NUM_ROWS*ROW_BITS-1:0] rows,
    output logic [ROW_BITS-1:0]          keys
);
    logic [ROW_BITS-1:0] masked [NUM_ROWS];

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        assign masked[r] = row_sel_n[r] ? {ROW_BITS{1'b1}}
                                        : rows[r*ROW_BITS +: ROW_BITS];
    end

    always_comb begin
        keys = {ROW_BITS{1'b1}};
        for (int r = 0; r < NUM_ROWS; r++) begin
            keys = keys & masked[r];
        end
    end
endmodule

// File: rtl/kt_tape_bit.sv
module kt_tape_bit (
    input  logic load_mode,
    input  logic tape_in,
    input  logic old_issue,
    input  logic ear_last,
    input  logic mic_last,
    output logic tape_bit
);
    always_comb begin
        if (load_mode)      tape_bit = ~tape_in;
        else if (old_issue) tape_bit = ear_last | mic_last;
        else                tape_bit = ear_last;
    end
endmodule

// File: rtl/kt_port_top.sv
module kt_port_top #(
    parameter int NUM_ROWS = 8,
    parameter int ROW_BITS = 5,
    parameter int ADDR_W   = 16,
    parameter int JOY_BIT  = 5,
    parameter int EAR_POS  = 4,
    parameter int MIC_POS  = 3,
    parameter int BORDER_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [7:0]                   wr_data,
    input  logic                         rd_en,
    input  logic                         wr_en,
    input  logic [NUM_ROWS*ROW_BITS-1:0] key_rows,
    input  logic [7:0]                   joy_in,
    input  logic                         tape_in,
    input  logic                         load_mode,
    input  logic                         old_issue,
    output logic [7:0]                   rd_data,
    output logic [BORDER_W-1:0]          border,
    output logic                         ear_out,
    output logic                         mic_out
);
    import kt_pkg::*;

    localparam int ROW_LSB = ADDR_W - NUM_ROWS;

    kt_state_t st_d, st_q;
    logic [ROW_BITS-1:0] keys;
    logic                tape_bit;
    logic [7:0]          kbd_byte;

    kt_row_scan #(.NUM_ROWS(NUM_ROWS), .ROW_BITS(ROW_BITS)) u_scan (
        .row_sel_n (addr[ADDR_W-1:ROW_LSB]),
        .rows      (key_rows),
        .keys      (keys)
    );

    kt_tape_bit u_tape (
        .load_mode (load_mode),
        .tape_in   (tape_in),
        .old_issue (old_issue),
        .ear_last  (st_q.last_wr[EAR_POS]),
        .mic_last  (st_q.last_wr[MIC_POS]),
        .tape_bit  (tape_bit)
    );

    always_comb begin
        kbd_byte = 8'hA0;
        kbd_byte[ROW_BITS-1:0] = keys;
        kbd_byte[6] = tape_bit;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && !addr[0]) st_d.last_wr = wr_data;
        if (rd_en) begin
            if (!addr[JOY_BIT])  st_d.rd = joy_in;
            else if (!addr[0])   st_d.rd = kbd_byte;
            else                 st_d.rd = 8'hFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.last_wr <= '0;
            st_q.rd      <= 8'hFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;
    assign border  = st_q.last_wr[BORDER_W-1:0];
    assign ear_out = st_q.last_wr[EAR_POS];
    assign mic_out = st_q.last_wr[MIC_POS];

    AST_EVEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr[0]) |=> (border == $past(wr_data[BORDER_W-1:0])
                                 && ear_out == $past(wr_data[EAR_POS])
                                 && mic_out == $past(wr_data[MIC_POS]))); // R1
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !addr[0]) |=> $stable({border, ear_out, mic_out})); // R1
    AST_FIXED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[JOY_BIT] && !addr[0]) |=> (rd_data[7] && rd_data[5])); // R3
    AST_LOAD_TAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[JOY_BIT] && !addr[0] && load_mode)
            |=> (rd_data[6] == !$past(tape_in))); // R4
    AST_JOY_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr[JOY_BIT]) |=> (rd_data == $past(joy_in))); // R7
    AST_ODD_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[JOY_BIT] && addr[0]) |=> (rd_data == 8'hFF)); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R9
endmodule

// File: tb/kt_port_top_tb_top.sv
module kt_port_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [39:0] key_rows = '1;
    logic [7:0]  joy_in = '0;
    logic        tape_in = 1'b0, load_mode = 1'b0, old_issue = 1'b0;
    logic [7:0]  rd_data;
    logic [2:0]  border;
    logic        ear_out, mic_out;

    int n_chk = 0, n_bad = 0;
    logic [7:0] model_last = '0;

    always #10 clk = ~clk;

    kt_port_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .rd_en(rd_en), .wr_en(wr_en), .key_rows(key_rows), .joy_in(joy_in),
        .tape_in(tape_in), .load_mode(load_mode), .old_issue(old_issue),
        .rd_data(rd_data), .border(border), .ear_out(ear_out), .mic_out(mic_out)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] expect_rd(input logic [15:0] a);
        logic [4:0] k;
        logic b6;
        if (!a[5]) return joy_in;
        if (a[0])  return 8'hFF;
        k = 5'h1F;
        for (int r = 0; r < 8; r++) if (!a[8+r]) k &= key_rows[5*r +: 5];
        if (load_mode)      b6 = !tape_in;
        else if (old_issue) b6 = model_last[4] | model_last[3];
        else                b6 = model_last[4];
        return {1'b1, b6, 1'b1, k};
    endfunction

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        if (!a[0]) model_last = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [15:0] a);
        logic [7:0] e;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        e = expect_rd(a);
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rd_data, e);
    endtask

    task automatic t_reset();
        chk("R9 border", {5'd0, border}, 8'h00);
        chk("R9 ear/mic", {6'd0, ear_out, mic_out}, 8'h00);
        chk("R9 rd_data", rd_data, 8'hFF);
        do_read("R9 stored byte zero (R5 loop-back)", 16'hFEFE);
    endtask

    task automatic t_write();
        do_write(16'h00FE, 8'h15);
        chk("R1 border", {5'd0, border}, 8'h05);
        chk("R1 ear/mic", {6'd0, ear_out, mic_out}, 8'h02);
        do_write(16'h00FF, 8'h0A);
        chk("R1 odd write ignored", {3'd0, ear_out, mic_out, border}, 8'h15);
        do_read("R5 ear loop-back 1", 16'hFEFE);
    endtask

    task automatic t_keys();
        key_rows[0 +: 5]  = 5'h1E;
        key_rows[15 +: 5] = 5'h17;
        key_rows[35 +: 5] = 5'h0F;
        do_read("R2 single row", 16'hFEFE);
        do_read("R2 two rows ANDed", 16'hF6FE);
        do_read("R2 no row", 16'hFFFE);
        do_read("R2 all rows (R3)", 16'h00FE);
        do_read("R2 top row", 16'h7FFE);
    endtask

    task automatic t_issue();
        for (int i = 0; i < 4; i++) begin
            do_write(16'h00FE, 8'(i << 3));
            old_issue = 1'b0; do_read("R5 new issue", 16'hFEFE);
            old_issue = 1'b1; do_read("R6 old issue", 16'hFEFE);
        end
        old_issue = 1'b0;
    endtask

    task automatic t_load();
        do_write(16'h00FE, 8'h18);
        load_mode = 1'b1;
        tape_in = 1'b1; do_read("R4 tape active", 16'hFEFE);
        tape_in = 1'b0; do_read("R4 tape idle", 16'hFEFE);
        load_mode = 1'b0;
    endtask

    task automatic t_joy_odd();
        joy_in = 8'h5A;
        do_read("R7 joystick even", 16'hFEDE);
        do_read("R7 joystick odd", 16'h00DF);
        do_read("R8 odd unclaimed", 16'hFFFF);
        do_read("R8 odd rows low", 16'h00FF);
        do_read("R7 before hold", 16'h0000);
        joy_in = 8'hC3;
        @(negedge clk); @(negedge clk);
        chk("R9 hold without read", rd_data, 8'h5A);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_keys();
        t_issue();
        t_load();
        t_joy_odd();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule